// File: doc/BRIEF.md
# Dual-Rail Serial Word Transmitter

This block sends 32-bit words over a two-rail return-to-zero serial line. One rail pulses for every zero bit and the other pulses for every one bit. In the second half of each bit cell both rails rest low. The block runs from a transmit clock at four times the bit rate. Each bit therefore takes four clocks: the selected rail is high for two clocks and both rails are low for the next two.

A host supplies each word as four bytes through an 8-bit write port with a single-byte holding register. Bytes are sent while the word is already going out. The host writes the next byte whenever the ready output is high. If the holding register is still empty when the byte on the line runs out, the block raises a sticky underwrite flag and abandons the word.

When parity is enabled, the final bit of the word is replaced by an odd-parity bit. An active-low clear-to-send input gates the start of every bit cell. An active-low busy output marks the span of a word. Between words the rails stay low for at least four bit times.

Top module: `dual_rail_word_tx`

## Requirements
- R1: Every bit cell lasts four clocks. The selected rail is high for exactly two consecutive clocks and then both rails are low for two clocks. Both rails are never high together.
- R2: A logic 1 pulses `rail_one` and a logic 0 pulses `rail_zero`.
- R3: A word consists of four bytes. The first byte written after the word starts is sent first, and each byte is sent least significant bit first. Bit 0 of the word is therefore bit 0 of the first byte, and bit 31 is bit 7 of the fourth byte.
- R4: With `par_en` high, bit 31 on the line equals the inversion of the XOR of bits 0..30, so the 32 bits contain an odd number of ones. With `par_en` low, bit 31 is the data bit.
- R5: After the last bit cell of a word, both rails stay low for at least four bit times (16 clocks) before the next word's first pulse. Counting the low half of the last cell, the rails are low for at least 18 clocks.
- R6: A bit cell begins only while `cts_n` is low. While `cts_n` is high at a cell boundary, transmission pauses with both rails low and then resumes with no bit lost or repeated.
- R7: `busy_n` is low from the start of a word until its last bit cell (or the abandoning of the word) ends, and high at all other times.
- R8: `rdy` is high exactly when the holding register is empty. A `wr_stb` pulse while `rdy` is low is ignored and changes neither the held byte nor the transmitted data.
- R9: If the holding register is empty when the eighth bit of a byte other than the last one ends, `underwrite` goes high. The word is abandoned (`busy_n` high, rails low), and `underwrite` stays high until reset.
- R10: While `rst` is high, both rails are low, `busy_n` and `rdy` are high, and `underwrite` is low. A byte pending in the holding register is discarded and is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, four times the bit rate |
| rst | input | 1 | Master reset, active high |
| par_en | input | 1 | Replace bit 31 with odd parity when high |
| cts_n | input | 1 | Clear to send, active low |
| wr_stb | input | 1 | One-clock byte write strobe |
| wr_byte | input | 8 | Byte to load into the holding register |
| rdy | output | 1 | Holding register empty, next byte may be written |
| busy_n | output | 1 | Low while a word is in progress |
| rail_zero | output | 1 | Pulses for each zero bit |
| rail_one | output | 1 | Pulses for each one bit |
| underwrite | output | 1 | Sticky flag: a byte arrived too late |

## Verification
The bench drives words with all-zero, all-one and mixed patterns, with and without parity. A design that mis-orders bytes or bits, or computes even instead of odd parity, then returns a different decoded word. It holds `cts_n` high both before a word and in the middle of one. A design that ignores the gate would emit pulses during the hold, and one that loses its place would drop or repeat a bit. It writes a junk byte while the holding register is full, so that a design that accepts it would corrupt the word. It starves the block after one byte to provoke the underwrite flag. It also resets with a byte pending; a design that fails to clear that byte would start a spurious word.

// File: rtl/dual_rail_word_tx.sv
module dual_rail_word_tx #(
  parameter int BYTES_PER_WORD = 4,
  parameter int GAP_BITS       = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       par_en,
  input  logic       cts_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  output logic       rdy,
  output logic       busy_n,
  output logic       rail_zero,
  output logic       rail_one,
  output logic       underwrite
);
  localparam int WORD_BITS = 8 * BYTES_PER_WORD;
  localparam int CW        = $clog2(WORD_BITS);
  localparam int GAP_CLKS  = 4 * GAP_BITS;
  localparam int GW        = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {IDLE, SEND, GAP} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [CW-1:0] bitn;
  logic [7:0]    shf;
  logic [7:0]    hold;
  logic          hold_full;
  logic          par_acc;
  logic          uw;
  logic [GW-1:0] gcnt;

  wire last_bit = bitn == CW'(WORD_BITS - 1);
  wire byte_end = bitn[2:0] == 3'd7;
  wire cur      = (par_en && last_bit) ? ~par_acc : shf[0];
  wire stall    = (st == SEND) && (ph == 2'd0) && cts_n;
  wire pulse    = (st == SEND) && !ph[1] && !stall;
  wire load     = wr_stb && !hold_full;

  assign rail_one   = pulse && cur;
  assign rail_zero  = pulse && !cur;
  assign busy_n     = st != SEND;
  assign rdy        = !hold_full;
  assign underwrite = uw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= IDLE;
      ph        <= 2'd0;
      bitn      <= '0;
      shf       <= 8'd0;
      hold      <= 8'd0;
      hold_full <= 1'b0;
      par_acc   <= 1'b0;
      uw        <= 1'b0;
      gcnt      <= '0;
    end else begin
      if (load) begin
        hold      <= wr_byte;
        hold_full <= 1'b1;
      end
      case (st)
        IDLE: begin
          if (hold_full && !cts_n) begin
            st        <= SEND;
            shf       <= hold;
            hold_full <= 1'b0;
            ph        <= 2'd0;
            bitn      <= '0;
            par_acc   <= 1'b0;
          end
        end
        SEND: begin
          if (!stall) begin
            ph <= ph + 2'd1;
            if (ph == 2'd3) begin
              par_acc <= par_acc ^ cur;
              if (last_bit) begin
                st   <= GAP;
                gcnt <= '0;
              end else if (byte_end) begin
                if (hold_full) begin
                  shf       <= hold;
                  hold_full <= 1'b0;
                  bitn      <= bitn + CW'(1);
                end else begin
                  uw   <= 1'b1;
                  st   <= GAP;
                  gcnt <= '0;
                end
              end else begin
                shf  <= shf >> 1;
                bitn <= bitn + CW'(1);
              end
            end
          end
        end
        GAP: begin
          if (gcnt == GW'(GAP_CLKS - 1)) st <= IDLE;
          else gcnt <= gcnt + GW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module dual_rail_word_tx_chk (
  input logic clk,
  input logic rst,
  input logic cts_n,
  input logic wr_stb,
  input logic rdy,
  input logic busy_n,
  input logic rail_zero,
  input logic rail_one,
  input logic underwrite
);
  // R1
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(rail_zero && rail_one));
  // R1
  one_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_one) |=> rail_one);
  // R1
  zero_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_zero) |=> rail_zero);
  // R1
  one_rz_chk: assert property (@(posedge clk) disable iff (rst)
    (rail_one && $past(rail_one)) |=> !rail_one);
  // R1
  zero_rz_chk: assert property (@(posedge clk) disable iff (rst)
    (rail_zero && $past(rail_zero)) |=> !rail_zero);
  // R6
  start_cts_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_zero || rail_one) |-> !cts_n);
  // R7
  busy_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (rail_zero || rail_one) |-> !busy_n);
  // R8
  rdy_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && rdy) |=> !rdy);
  // R9
  uw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underwrite |=> underwrite);
endmodule

bind dual_rail_word_tx dual_rail_word_tx_chk i_chk (
  .clk(clk), .rst(rst), .cts_n(cts_n), .wr_stb(wr_stb), .rdy(rdy),
  .busy_n(busy_n), .rail_zero(rail_zero), .rail_one(rail_one),
  .underwrite(underwrite)
);

// File: tb/test_dual_rail_word_tx.sv
module test_dual_rail_word_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_en = 1'b0;
  logic cts_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'd0;
  logic rdy, busy_n, rail_zero, rail_one, underwrite;

  always #5 clk = ~clk;

  dual_rail_word_tx i_dual_rail_word_tx (
    .clk(clk), .rst(rst), .par_en(par_en), .cts_n(cts_n), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rdy(rdy), .busy_n(busy_n), .rail_zero(rail_zero),
    .rail_one(rail_one), .underwrite(underwrite)
  );

  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000}, {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h0000_0000},
    {1'b1, 32'hA5C3_1E77}, {1'b0, 32'h8000_0001}, {1'b1, 32'h7FFF_FFFF}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic p, input logic [31:0] d);
    return p ? {~(^d[30:0]), d[30:0]} : d;
  endfunction

  logic [31:0] rx_word;
  logic [31:0] got [16];
  int rx_cnt = 0, nwords = 0, npulses = 0, hi_run = 0, lo_run = 0;
  bit prev_any = 0, gap_arm = 0;

  always @(negedge clk) begin
    if (rst) begin
      rx_cnt = 0; prev_any = 0; hi_run = 0; lo_run = 0; gap_arm = 0;
    end else begin
      if (rail_zero && rail_one) check(0, "R1 both rails high", 1, 0);
      if ((rail_zero || rail_one) && !prev_any) begin
        if (rx_cnt == 0 && gap_arm)
          check(lo_run >= 18, "R5 inter-word gap", lo_run, 18);
        rx_word[rx_cnt] = rail_one;
        rx_cnt++;
        npulses++;
        hi_run = 1;
      end else if (rail_zero || rail_one) begin
        hi_run++;
      end
      if (!(rail_zero || rail_one) && prev_any)
        check(hi_run == 2, "R1 pulse width", hi_run, 2);
      lo_run = (rail_zero || rail_one) ? 0 : lo_run + 1;
      prev_any = rail_zero || rail_one;
      if (rx_cnt == 32) begin
        got[nwords] = rx_word;
        nwords++;
        rx_cnt = 0;
        gap_arm = 1;
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rdy) @(negedge clk);
    wr_stb = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    int snap;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rdy && busy_n && !underwrite && !rail_zero && !rail_one, "R10 reset state",
          {rdy, busy_n, underwrite, rail_zero, rail_one}, 5'b11000);
    rst = 1'b0;

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      if (i > 0 && VEC[i][32] != VEC[i-1][32]) begin
        while (nwords != i) @(negedge clk);
        repeat (4) @(negedge clk);
      end
      par_en = VEC[i][32];
      for (int b = 0; b < 4; b++) write_byte(VEC[i][8*b +: 8]);
    end
    while (nwords != NV) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int i = 0; i < NV; i++)
      check(got[i] === exp_word(VEC[i][32], VEC[i][31:0]), "R2/R3/R4 word data",
            got[i], exp_word(VEC[i][32], VEC[i][31:0]));
    // R7 idle between words
    check(busy_n === 1'b1, "R7 busy_n idle", busy_n, 1);

    // R6 hold before start, R8 ignored write, R7 busy during pause
    par_en = 1'b0;
    base = nwords;
    cts_n = 1'b1;
    write_byte(8'h78);
    snap = npulses;
    repeat (60) @(negedge clk);
    check(npulses == snap && busy_n, "R6 no start while cts_n high", npulses, snap);
    check(rdy === 1'b0, "R8 rdy low with byte held", rdy, 0);
    cts_n = 1'b0;
    write_byte(8'h56);
    write_byte(8'h34);
    // R8 write while full
    check(rdy === 1'b0, "R8 rdy low before junk write", rdy, 0);
    wr_stb = 1'b1; wr_byte = 8'hEE;
    @(negedge clk);
    wr_stb = 1'b0;
    cts_n = 1'b1;
    repeat (8) @(negedge clk);
    snap = npulses;
    repeat (80) @(negedge clk);
    check(npulses == snap, "R6 paused mid-word", npulses, snap);
    check(busy_n === 1'b0, "R7 busy_n low during pause", busy_n, 0);
    check(underwrite === 1'b0, "R9 no underwrite during pause", underwrite, 0);
    cts_n = 1'b0;
    write_byte(8'h12);
    while (nwords != base + 1) @(negedge clk);
    check(got[base] === 32'h1234_5678, "R6/R8 word after pause and junk write",
          got[base], 32'h1234_5678);

    // R9 underwrite
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    write_byte(8'h3C);
    snap = 0;
    while (!underwrite && snap < 400) begin @(negedge clk); snap++; end
    check(underwrite === 1'b1, "R9 underwrite raised", underwrite, 1);
    check(busy_n === 1'b1, "R9 word abandoned", busy_n, 1);
    check(rx_cnt == 8 && rx_word[7:0] == 8'h3C, "R9 first byte sent", {rx_cnt[23:0], rx_word[7:0]},
          {24'd8, 8'h3C});
    snap = npulses;
    repeat (50) @(negedge clk);
    check(underwrite === 1'b1 && npulses == snap, "R9 flag sticky, line quiet",
          {underwrite, npulses[30:0]}, {1'b1, snap[30:0]});

    // R10 reset mid-word with a byte pending
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    write_byte(8'hA1);
    write_byte(8'hB2);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!rail_zero && !rail_one && busy_n && rdy && !underwrite, "R10 reset mid-word",
          {rail_zero, rail_one, busy_n, rdy, underwrite}, 5'b00110);
    @(negedge clk);
    rst = 1'b0;
    snap = npulses;
    repeat (100) @(negedge clk);
    check(npulses == snap && busy_n, "R10 pending byte discarded", npulses, snap);

    finish_run();
  end
endmodule